// File: doc/BRIEF.md
# ALU Flag Generator With Inverted Borrow

This block is the arithmetic and flag stage of a small 8-bit processor core. Each cycle it may accept one operation: an operation code, two operands and the current carry. One cycle later it presents the 8-bit result, the zero, digit-carry and carry flag values, and three update enables. The enables tell the status storage, which sits outside this block, which flags the operation is allowed to change.

Subtraction is carried out as an addition of the first operand and the two's complement of the second. The carry and digit-carry outputs are therefore the plain adder carries, and they read as inverted borrows: 1 means nothing was borrowed. The two rotate operations shift through the carry. The old carry fills the vacated bit, and the bit shifted out becomes the new carry. Logic operations only touch the zero flag.

Operation codes, on `opCode`: 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, 5 complement of A, 6 move A with test, 7 rotate right through carry, 8 rotate left through carry, 9 to 15 undefined.

Top module: `alu_flag_gen`

## Requirements
- R1: For opcode 0, `{carryFlag,result}` equals opA+opB as a 9-bit sum. `digitCarry` is the carry out of bits 3..0, that is opA[3:0]+opB[3:0] > 15. All three update enables are 1.
- R2: For opcode 1, `{carryFlag,result}` equals opA + (~opB) + 1 as a 9-bit sum. `digitCarry` is bit 4 of opA[3:0] + (~opB)[3:0] + 1. All three update enables are 1.
- R3: For opcodes 0 to 6, `zeroFlag` is 1 exactly when `result` is 0x00.
- R4: Opcodes 2 to 6 give opA&opB, opA|opB, opA^opB, ~opA and opA in turn. Only `zeroUpd` is 1 for them, and `digitCarry` and `carryFlag` read 0.
- R5: Opcode 7 gives {carryIn, opA[7:1]} with `carryFlag` = opA[0]. Opcode 8 gives {opA[6:0], carryIn} with `carryFlag` = opA[7]. For both, only `carryUpd` is 1, and `zeroFlag` and `digitCarry` read 0.
- R6: Subtracting equal operands gives result 0 with zero, digit-carry and carry all 1. Subtracting a larger opB from a smaller opA gives `carryFlag` 0.
- R7: An operation accepted with `inValid` high appears on the outputs, with `outValid` high, at the next rising clock edge. `outValid` is 0 after a cycle with `inValid` low.
- R8: While `rst_n` is low, all outputs are 0.
- R9: Opcodes 9 to 15 pass opA to `result`. All flag values and all update enables are 0 for them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation present this cycle |
| opCode | input | 4 | Operation select |
| opA | input | 8 | First operand / rotate source |
| opB | input | 8 | Second operand |
| carryIn | input | 1 | Current carry flag |
| outValid | output | 1 | Result and flags valid |
| result | output | 8 | Operation result |
| zeroFlag | output | 1 | Zero flag value |
| digitCarry | output | 1 | Low-nibble carry (inverted borrow on subtract) |
| carryFlag | output | 1 | Carry (inverted borrow on subtract, shifted-out bit on rotate) |
| zeroUpd | output | 1 | Operation updates zero |
| dcUpd | output | 1 | Operation updates digit carry |
| carryUpd | output | 1 | Operation updates carry |

## Verification
The assertions look one cycle back at the decoded strobes and the operands. They assume that the operands and the carry are known whenever `inValid` is high, and that reset has been held for at least one clock edge. The stimulus drives every input on the falling edge, so all inputs are stable and defined at each rising edge. It also holds reset low over several edges before the first operation. Add and subtract are exercised over every operand pair. The other opcodes use chosen patterns that include zero results, both carry-in values and both edge bits.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;
  localparam logic [3:0] OP_ADD  = 4'd0;
  localparam logic [3:0] OP_SUB  = 4'd1;
  localparam logic [3:0] OP_AND  = 4'd2;
  localparam logic [3:0] OP_OR   = 4'd3;
  localparam logic [3:0] OP_XOR  = 4'd4;
  localparam logic [3:0] OP_NOT  = 4'd5;
  localparam logic [3:0] OP_MOVT = 4'd6;
  localparam logic [3:0] OP_RRC  = 4'd7;
  localparam logic [3:0] OP_RLC  = 4'd8;

  typedef enum logic [2:0] {
    LG_AND, LG_OR, LG_XOR, LG_NOT, LG_PASS
  } logicSel_e;

  typedef struct packed {
    logic      load;
    logic      doArith;
    logic      doSub;
    logic      doLogic;
    logicSel_e logicSel;
    logic      doRotR;
    logic      doRotL;
    logic      updZ;
    logic      updDc;
    logic      updC;
  } aluStrobe_t;
endpackage

// File: rtl/alu_flag_ctrl.sv
module alu_flag_ctrl
  import alu_flag_pkg::*;
(
  input  logic       inValid,
  input  logic [3:0] opCode,
  output aluStrobe_t strobe
);
  always_comb begin
    strobe          = '0;
    strobe.load     = inValid;
    strobe.logicSel = LG_PASS;
    unique case (opCode)
      OP_ADD, OP_SUB: begin
        strobe.doArith = 1'b1;
        strobe.doSub   = (opCode == OP_SUB);
        strobe.updZ    = 1'b1;
        strobe.updDc   = 1'b1;
        strobe.updC    = 1'b1;
      end
      OP_AND, OP_OR, OP_XOR, OP_NOT, OP_MOVT: begin
        strobe.doLogic = 1'b1;
        strobe.updZ    = 1'b1;
        case (opCode)
          OP_AND:  strobe.logicSel = LG_AND;
          OP_OR:   strobe.logicSel = LG_OR;
          OP_XOR:  strobe.logicSel = LG_XOR;
          OP_NOT:  strobe.logicSel = LG_NOT;
          default: strobe.logicSel = LG_PASS;
        endcase
      end
      OP_RRC: begin
        strobe.doRotR = 1'b1;
        strobe.updC   = 1'b1;
      end
      OP_RLC: begin
        strobe.doRotL = 1'b1;
        strobe.updC   = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu_flag_dp.sv
module alu_flag_dp
  import alu_flag_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  aluStrobe_t        strobe,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              carryIn,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic              zeroFlag,
  output logic              digitCarry,
  output logic              carryFlag,
  output logic              zeroUpd,
  output logic              dcUpd,
  output logic              carryUpd
);
  localparam int SUM_W = DATA_W + 1;
  localparam int LOW_W = NIB_W + 1;

  logic [DATA_W-1:0] addend;
  logic [SUM_W-1:0]  fullSum;
  logic [LOW_W-1:0]  lowSum;
  logic [DATA_W-1:0] logicRes;
  logic [DATA_W-1:0] nextRes;
  logic              nextC, nextDc, nextZ;

  // subtract = A + ~B + 1, so the carries read as inverted borrows
  assign addend  = strobe.doSub ? ~opB : opB;
  assign fullSum = {1'b0, opA} + {1'b0, addend} + SUM_W'(strobe.doSub);
  assign lowSum  = {1'b0, opA[NIB_W-1:0]} + {1'b0, addend[NIB_W-1:0]}
                 + LOW_W'(strobe.doSub);

  always_comb begin
    unique case (strobe.logicSel)
      LG_AND:  logicRes = opA & opB;
      LG_OR:   logicRes = opA | opB;
      LG_XOR:  logicRes = opA ^ opB;
      LG_NOT:  logicRes = ~opA;
      default: logicRes = opA;
    endcase
  end

  always_comb begin
    nextRes = opA;
    nextC   = 1'b0;
    nextDc  = 1'b0;
    if (strobe.doArith) begin
      nextRes = fullSum[DATA_W-1:0];
      nextC   = fullSum[DATA_W];
      nextDc  = lowSum[NIB_W];
    end else if (strobe.doLogic) begin
      nextRes = logicRes;
    end else if (strobe.doRotR) begin
      nextRes = {carryIn, opA[DATA_W-1:1]};
      nextC   = opA[0];
    end else if (strobe.doRotL) begin
      nextRes = {opA[DATA_W-2:0], carryIn};
      nextC   = opA[DATA_W-1];
    end
    nextZ = strobe.updZ && (nextRes == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid   <= 1'b0;
      result     <= '0;
      zeroFlag   <= 1'b0;
      digitCarry <= 1'b0;
      carryFlag  <= 1'b0;
      zeroUpd    <= 1'b0;
      dcUpd      <= 1'b0;
      carryUpd   <= 1'b0;
    end else begin
      outValid <= strobe.load;
      if (strobe.load) begin
        result     <= nextRes;
        zeroFlag   <= nextZ;
        digitCarry <= nextDc;
        carryFlag  <= nextC;
        zeroUpd    <= strobe.updZ;
        dcUpd      <= strobe.updDc;
        carryUpd   <= strobe.updC;
      end
    end
  end

  p_add_sum_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && $past(strobe.doArith && !strobe.doSub))
      |-> ({carryFlag, result} == ({1'b0, $past(opA)} + {1'b0, $past(opB)})));

  p_logic_upd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && $past(strobe.doLogic)) |-> (zeroUpd && !dcUpd && !carryUpd));

  p_rotr_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && $past(strobe.doRotR))
      |-> (carryFlag == $past(opA[0]) && carryUpd && !zeroUpd && !dcUpd));

  p_sub_equal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && $past(strobe.doSub) && ($past(opA) == $past(opB)))
      |-> (result == '0 && zeroFlag && digitCarry && carryFlag));

  p_valid_lag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.load |=> outValid);

  p_valid_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.load |=> !outValid);
endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen
  import alu_flag_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  input  logic [3:0]        opCode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              carryIn,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic              zeroFlag,
  output logic              digitCarry,
  output logic              carryFlag,
  output logic              zeroUpd,
  output logic              dcUpd,
  output logic              carryUpd
);
  aluStrobe_t strobe;

  alu_flag_ctrl ctrl_i (
    .inValid (inValid),
    .opCode  (opCode),
    .strobe  (strobe)
  );

  alu_flag_dp #(.DATA_W(DATA_W), .NIB_W(NIB_W)) dp_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .opA        (opA),
    .opB        (opB),
    .carryIn    (carryIn),
    .outValid   (outValid),
    .result     (result),
    .zeroFlag   (zeroFlag),
    .digitCarry (digitCarry),
    .carryFlag  (carryFlag),
    .zeroUpd    (zeroUpd),
    .dcUpd      (dcUpd),
    .carryUpd   (carryUpd)
  );

  p_rst_quiet_r8: assert property (@(posedge clk)
    !rst_n |=> (!outValid && result == '0 && !zeroUpd && !dcUpd && !carryUpd));
endmodule

// File: tb/alu_flag_gen_tb_top.sv
module alu_flag_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       inValid = 1'b0;
  logic [3:0] opCode = '0;
  logic [7:0] opA = '0, opB = '0;
  logic       carryIn = 1'b0;
  logic       outValid, zeroFlag, digitCarry, carryFlag, zeroUpd, dcUpd, carryUpd;
  logic [7:0] result;

  int total = 0;
  int bad = 0;

  typedef struct {
    int         req;
    logic [7:0] res;
    logic       z, dc, c, zu, dcu, cu;
  } expItem_t;

  expItem_t sbQ[$];

  always #2 clk = ~clk;  // 250 MHz

  alu_flag_gen dut_i (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .opCode(opCode),
    .opA(opA), .opB(opB), .carryIn(carryIn), .outValid(outValid),
    .result(result), .zeroFlag(zeroFlag), .digitCarry(digitCarry),
    .carryFlag(carryFlag), .zeroUpd(zeroUpd), .dcUpd(dcUpd), .carryUpd(carryUpd)
  );

  function automatic expItem_t model(input logic [3:0] op, input logic [7:0] a,
                                     input logic [7:0] b, input logic ci, input int req);
    expItem_t e;
    logic [8:0] s;
    logic [4:0] n;
    e = '{req: req, res: a, z: 0, dc: 0, c: 0, zu: 0, dcu: 0, cu: 0};
    case (op)
      4'd0: begin s = a + b; n = a[3:0] + b[3:0];  // R1
        e.res = s[7:0]; e.c = s[8]; e.dc = n[4]; e.zu = 1; e.dcu = 1; e.cu = 1; end
      4'd1: begin s = {1'b0, a} + {1'b0, ~b} + 9'd1;  // R2
        n = {1'b0, a[3:0]} + {1'b0, ~b[3:0]} + 5'd1;
        e.res = s[7:0]; e.c = s[8]; e.dc = n[4]; e.zu = 1; e.dcu = 1; e.cu = 1; end
      4'd2: begin e.res = a & b; e.zu = 1; end  // R4
      4'd3: begin e.res = a | b; e.zu = 1; end
      4'd4: begin e.res = a ^ b; e.zu = 1; end
      4'd5: begin e.res = ~a;    e.zu = 1; end
      4'd6: begin e.res = a;     e.zu = 1; end
      4'd7: begin e.res = {ci, a[7:1]}; e.c = a[0]; e.cu = 1; end  // R5
      4'd8: begin e.res = {a[6:0], ci}; e.c = a[7]; e.cu = 1; end
      default: ;  // R9
    endcase
    if (e.zu) e.z = (e.res == 8'h00);  // R3
    return e;
  endfunction

  task automatic send(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                      input logic ci, input int req);
    @(negedge clk);
    inValid = 1'b1; opCode = op; opA = a; opB = b; carryIn = ci;
    sbQ.push_back(model(op, a, b, ci, req));
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic check(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // monitor: pop and compare each produced result
  always @(negedge clk) begin
    if (rst_n && outValid) begin
      if (sbQ.size() == 0) begin
        check(0, "R7 unexpected outValid", 1, 0);
      end else begin
        expItem_t e;
        logic [13:0] act, exp;
        e = sbQ.pop_front();
        act = {result, zeroFlag, digitCarry, carryFlag, zeroUpd, dcUpd, carryUpd};
        exp = {e.res, e.z, e.dc, e.c, e.zu, e.dcu, e.cu};
        check(act == exp, $sformatf("R%0d op result/flags {res,z,dc,c,zu,dcu,cu}", e.req),
              int'(act), int'(exp));
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    check({outValid, result, zeroFlag, digitCarry, carryFlag, zeroUpd, dcUpd, carryUpd} == '0,
          "R8 reset outputs", int'({outValid, result}), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0, "R7 outValid idle", outValid, 0);

    // R6: equal and smaller-minus-larger subtraction
    send(4'd1, 8'h5A, 8'h5A, 1'b0, 6);
    send(4'd1, 8'h00, 8'h00, 1'b1, 6);
    send(4'd1, 8'h10, 8'h11, 1'b0, 6);
    send(4'd1, 8'h03, 8'hF0, 1'b0, 6);
    // R4 and R3: logic ops, including zero results
    send(4'd2, 8'hF0, 8'h0F, 1'b1, 3);
    send(4'd2, 8'hCC, 8'hAA, 1'b0, 4);
    send(4'd3, 8'h00, 8'h00, 1'b1, 3);
    send(4'd3, 8'h81, 8'h18, 1'b0, 4);
    send(4'd4, 8'h77, 8'h77, 1'b0, 3);
    send(4'd4, 8'h0F, 8'h3C, 1'b1, 4);
    send(4'd5, 8'hFF, 8'h00, 1'b1, 3);
    send(4'd5, 8'h12, 8'h00, 1'b0, 4);
    send(4'd6, 8'h00, 8'hFF, 1'b1, 3);
    send(4'd6, 8'hA5, 8'h00, 1'b0, 4);
    // R5: rotates through carry, both carry-in values and edge bits
    for (int i = 0; i < 4; i++) begin
      send(4'd7, (i[0] ? 8'h01 : 8'h80), 8'h00, i[1], 5);
      send(4'd8, (i[0] ? 8'h80 : 8'h01), 8'h00, i[1], 5);
    end
    send(4'd7, 8'h00, 8'h00, 1'b0, 5);  // zero result, Z not updated
    // R9: undefined opcodes
    for (int op = 9; op < 16; op++) send(4'(op), 8'(op * 17), 8'hFF, 1'b1, 9);
    // R7: gap then outValid must drop
    idle(); idle();
    check(outValid == 1'b0, "R7 outValid low after idle", outValid, 0);
    // R1/R2 exhaustive
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++) send(4'd0, 8'(a), 8'(b), 1'b0, 1);
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++) send(4'd1, 8'(a), 8'(b), 1'b1, 2);
    idle(); idle();
    check(sbQ.size() == 0, "R7 all results produced", sbQ.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule